// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Status Flags

This block is the arithmetic part of an accumulator-style 8-bit datapath. Each cycle it takes the current accumulator, the second operand register and the program status byte. When an operation is launched, it computes one of five arithmetic operations: add, add with carry, subtract with borrow, unsigned multiply and unsigned divide. The results, the rebuilt status byte and write strobes come out one clock later. The register file around the block uses those strobes to decide which of its registers to update.

The status byte is rebuilt every cycle, including cycles with no operation. The parity bit always tracks the accumulator value that will hold once the strobes are applied. Bits the unit does not own pass through unchanged: the general flag, the two bank-select bits and the spare user bit. The unit also turns the two bank-select bits into the base address of the active eight-register bank, for use by the register-file wrapper.

Top module: `alu8_core`

## Requirements
- R1: With `rst` high at a clock edge, the next outputs are all zero: data outputs, status byte, strobes and bank base.
- R2: Results appear one cycle after launch. Launch means `op_go` high with `op_sel` 1 (add). The accumulator result is (acc+b) mod 256. Status bit 7 (carry) is the carry out of bit 7.
- R3: Status bit 6 (half carry) is the carry out of bit 3 into bit 4 for add and add-with-carry. For subtract it is the borrow into bit 3 from bit 4. Multiply and divide pass it through unchanged.
- R4: Status bit 2 (overflow) is set for add, add-with-carry and subtract when the two's-complement result lies outside -128..+127.
- R5: `op_sel` 2 adds the incoming carry (status input bit 7). `op_sel` 3 computes acc-b-carry. For subtract, bit 7 of the status byte is set when that subtraction borrows.
- R6: `op_sel` 4 multiplies unsigned. The low product byte goes to `acc_out` and the high byte to `b_out`. Carry is cleared, and overflow is set exactly when the product exceeds 255.
- R7: `op_sel` 5 divides unsigned. The quotient goes to `acc_out` and the remainder to `b_out`, and carry and overflow are cleared. With a zero divisor, overflow is set and carry cleared, and the data values are unspecified.
- R8: Status bit 0 is the odd-parity bit of the accumulator value in effect, updated every cycle. That value is the new result when `acc_we` is high, and otherwise `acc_in` from the previous cycle.
- R9: Status bits 5, 4, 3 and 1 equal the input status bits of the previous cycle. `bank_base` equals {status bit 4, status bit 3, 3'b000}.
- R10: `acc_we` and `psw_we` pulse for `op_sel` 1 to 5 with `op_go` high, and `b_we` pulses only for 4 and 5. Codes 0, 6 and 7, or `op_go` low, raise no strobe, and the status flags then pass through apart from parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_go | input | 1 | Launch the selected operation this cycle |
| op_sel | input | 3 | Operation code: 0 none, 1 add, 2 add+carry, 3 sub-borrow, 4 mul, 5 div |
| acc_in | input | 8 | Current accumulator value |
| b_in | input | 8 | Current second operand register |
| psw_in | input | 8 | Current status byte (carry, half carry, flag, bank1, bank0, overflow, user, parity) |
| acc_out | output | 8 | Accumulator result |
| b_out | output | 8 | Second-register result (high product byte or remainder) |
| psw_out | output | 8 | Rebuilt status byte |
| acc_we | output | 1 | Write strobe for the accumulator |
| b_we | output | 1 | Write strobe for the second register |
| psw_we | output | 1 | Write strobe for the arithmetic flags |
| bank_base | output | 5 | Base address of the selected register bank |

## Verification
Additions are tried near 7FH and FFH with low nibbles that do and do not overflow. This separates the carry, half-carry and signed-overflow conditions from one another. Subtractions with and without an incoming borrow, across zero and across 80H, separate borrow from overflow. Multiplies are tried with products just below and just above 255 and at FFH×FFH, and divides with remainders, with a divisor larger than the dividend and with a zero divisor. These cases expose swapped output bytes and wrong flag rules. Idle cycles, unused codes and a held-off launch with varied accumulator and bank bits show parity tracking and pass-through apart from any arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int PSW_W  = 8;
  localparam int CY_BIT = 7;
  localparam int AC_BIT = 6;
  localparam int F0_BIT = 5;
  localparam int BK1_BIT = 4;
  localparam int BK0_BIT = 3;
  localparam int OV_BIT = 2;
  localparam int UB_BIT = 1;
  localparam int P_BIT  = 0;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_ADDC = 3'd2,
    OP_SUBB = 3'd3,
    OP_MUL  = 3'd4,
    OP_DIV  = 3'd5
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } arith_flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = 8,
  parameter int H = 4
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          cin,
  input  logic          sub,
  output logic [W-1:0]  res,
  output arith_flags_t  flg
);
  logic [W:0] full;
  logic [H:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      half = {1'b0, a[H-1:0]} - {1'b0, b[H-1:0]} - {{H{1'b0}}, cin};
      flg.ov = (a[W-1] ^ b[W-1]) & (full[W-1] ^ a[W-1]);
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      half = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
      flg.ov = ~(a[W-1] ^ b[W-1]) & (full[W-1] ^ a[W-1]);
    end
    res    = full[W-1:0];
    flg.cy = full[W];
    flg.ac = half[H];
  end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         is_div,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ov
);
  logic [2*W-1:0] prod;

  always_comb begin
    prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    if (!is_div) begin
      lo = prod[W-1:0];
      hi = prod[2*W-1:W];
      ov = |prod[2*W-1:W];
    end else if (b == '0) begin
      lo = '0;
      hi = '0;
      ov = 1'b1;
    end else begin
      lo = a / b;
      hi = a % b;
      ov = 1'b0;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W      = 8,
  parameter int SLOT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_go,
  input  logic [2:0]            op_sel,
  input  logic [W-1:0]          acc_in,
  input  logic [W-1:0]          b_in,
  input  logic [PSW_W-1:0]      psw_in,
  output logic [W-1:0]          acc_out,
  output logic [W-1:0]          b_out,
  output logic [PSW_W-1:0]      psw_out,
  output logic                  acc_we,
  output logic                  b_we,
  output logic                  psw_we,
  output logic [SLOT_W+1:0]     bank_base
);
  localparam int HALF = W / 2;

  logic         do_arith, do_md, do_sub, carry_in;
  logic [W-1:0] as_res, md_lo, md_hi, acc_view;
  logic         md_ov;
  arith_flags_t as_flg;
  logic [PSW_W-1:0] psw_next;

  always_comb begin
    do_arith = op_go && (op_sel == OP_ADD || op_sel == OP_ADDC || op_sel == OP_SUBB);
    do_md    = op_go && (op_sel == OP_MUL || op_sel == OP_DIV);
    do_sub   = (op_sel == OP_SUBB);
    carry_in = (op_sel == OP_ADDC || op_sel == OP_SUBB) ? psw_in[CY_BIT] : 1'b0;
  end

  alu8_addsub #(.W(W), .H(HALF)) u_addsub (
    .a(acc_in), .b(b_in), .cin(carry_in), .sub(do_sub),
    .res(as_res), .flg(as_flg)
  );

  alu8_muldiv #(.W(W)) u_muldiv (
    .a(acc_in), .b(b_in), .is_div(op_sel == OP_DIV),
    .lo(md_lo), .hi(md_hi), .ov(md_ov)
  );

  always_comb begin
    psw_next = psw_in;
    acc_view = acc_in;
    if (do_arith) begin
      acc_view         = as_res;
      psw_next[CY_BIT] = as_flg.cy;
      psw_next[AC_BIT] = as_flg.ac;
      psw_next[OV_BIT] = as_flg.ov;
    end else if (do_md) begin
      acc_view         = md_lo;
      psw_next[CY_BIT] = 1'b0;
      psw_next[OV_BIT] = md_ov;
    end
    psw_next[P_BIT] = ^acc_view;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out   <= '0;
      b_out     <= '0;
      psw_out   <= '0;
      acc_we    <= 1'b0;
      b_we      <= 1'b0;
      psw_we    <= 1'b0;
      bank_base <= '0;
    end else begin
      psw_out   <= psw_next;
      acc_we    <= do_arith | do_md;
      psw_we    <= do_arith | do_md;
      b_we      <= do_md;
      bank_base <= {psw_in[BK1_BIT], psw_in[BK0_BIT], {SLOT_W{1'b0}}};
      if (do_arith | do_md) acc_out <= acc_view;
      if (do_md) b_out <= md_hi;
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!acc_we && !b_we && !psw_we && psw_out == '0));
  // R10
  bwe_pair_chk: assert property (@(posedge clk) disable iff (rst)
    b_we |-> (acc_we && psw_we));
  // R6
  md_carry_chk: assert property (@(posedge clk) disable iff (rst)
    b_we |-> !psw_out[CY_BIT]);
  // R8
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    acc_we |-> (psw_out[P_BIT] == ^acc_out));
  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (psw_out[F0_BIT:BK0_BIT] == $past(psw_in[F0_BIT:BK0_BIT])
                     && psw_out[UB_BIT] == $past(psw_in[UB_BIT])));
  // R9
  bank_chk: assert property (@(posedge clk) disable iff (rst)
    bank_base == {psw_out[BK1_BIT], psw_out[BK0_BIT], {SLOT_W{1'b0}}});
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_go = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] acc_in = 8'h00, b_in = 8'h00, psw_in = 8'h00;
  logic [7:0] acc_out, b_out, psw_out;
  logic       acc_we, b_we, psw_we;
  logic [4:0] bank_base;

  int nchk = 0;
  int nfail = 0;

  typedef struct {
    logic [7:0] a, b, psw;
    logic [4:0] bank;
    bit awe, bwe, pwe, dz;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .op_go(op_go), .op_sel(op_sel),
    .acc_in(acc_in), .b_in(b_in), .psw_in(psw_in),
    .acc_out(acc_out), .b_out(b_out), .psw_out(psw_out),
    .acc_we(acc_we), .b_we(b_we), .psw_we(psw_we), .bank_base(bank_base)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic drive(input bit go, input int op, input int a, input int b,
                       input int psw, input string tag);
    exp_t e;
    int c, s, sr, ra, rb, cy, ac, ov;
    bit act;
    @(negedge clk);
    op_go = go; op_sel = op[2:0]; acc_in = a[7:0]; b_in = b[7:0]; psw_in = psw[7:0];
    c = (psw >> 7) & 1;
    cy = c; ac = (psw >> 6) & 1; ov = (psw >> 2) & 1; ra = a; rb = b;
    act = go && op >= 1 && op <= 5;
    e.dz = 0;
    if (act) begin
      case (op)
        1, 2: begin
          int ci;
          ci = (op == 2) ? c : 0;
          s = a + b + ci; ra = s & 255; cy = (s > 255);
          ac = (((a & 15) + (b & 15) + ci) > 15);
          sr = sx(a) + sx(b) + ci; ov = (sr > 127 || sr < -128);
        end
        3: begin
          ra = (a - b - c) & 255; cy = (a < b + c);
          ac = ((a & 15) < (b & 15) + c);
          sr = sx(a) - sx(b) - c; ov = (sr > 127 || sr < -128);
        end
        4: begin
          s = a * b; ra = s & 255; rb = s >> 8; cy = 0; ov = (s > 255);
        end
        default: begin
          cy = 0;
          if (b == 0) begin ov = 1; e.dz = 1; end
          else begin ra = a / b; rb = a % b; ov = 0; end
        end
      endcase
    end
    e.a = ra[7:0]; e.b = rb[7:0];
    e.awe = act; e.pwe = act; e.bwe = act && (op == 4 || op == 5);
    e.psw = {cy[0], ac[0], psw[5:3], ov[0], psw[1], ^(act ? ra[7:0] : a[7:0])};
    e.bank = {psw[4:3], 3'b000};
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk({e.tag, " R10 acc_we"}, acc_we, e.awe);
        chk({e.tag, " R10 b_we"}, b_we, e.bwe);
        chk({e.tag, " R10 psw_we"}, psw_we, e.pwe);
        chk({e.tag, " R9 bank_base"}, bank_base, e.bank);
        if (e.dz) begin
          chk({e.tag, " R7 flags (zero divisor)"}, psw_out & 8'hFE, e.psw & 8'hFE);
        end else begin
          chk({e.tag, " R8 R9 status"}, psw_out, e.psw);
          if (e.awe) chk({e.tag, " acc_out"}, acc_out, e.a);
          if (e.bwe) chk({e.tag, " b_out"}, b_out, e.b);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    chk("R1 acc_out", acc_out, 0);
    chk("R1 b_out", b_out, 0);
    chk("R1 psw_out", psw_out, 0);
    chk("R1 strobes", {acc_we, b_we, psw_we}, 0);
    chk("R1 bank_base", bank_base, 0);
    rst = 1'b0;

    drive(1, 1, 8'h12, 8'h34, 8'h00, "R2 add plain");
    drive(1, 1, 8'hFF, 8'h01, 8'h00, "R2 R3 add wrap");
    drive(1, 1, 8'h7F, 8'h01, 8'h00, "R4 add ovf");
    drive(1, 1, 8'h80, 8'h80, 8'h00, "R4 add neg ovf");
    drive(1, 1, 8'h08, 8'h08, 8'h3A, "R3 half carry");
    drive(1, 2, 8'hFE, 8'h01, 8'h80, "R5 addc carry");
    drive(1, 2, 8'h0F, 8'h00, 8'h80, "R5 R3 addc nibble");
    drive(1, 3, 8'h00, 8'h01, 8'h00, "R5 subb borrow");
    drive(1, 3, 8'h80, 8'h01, 8'h00, "R4 subb ovf");
    drive(1, 3, 8'h50, 8'h10, 8'h80, "R5 subb with carry");
    drive(1, 3, 8'h10, 8'h01, 8'h18, "R3 subb half borrow");
    drive(1, 4, 8'h03, 8'h05, 8'hC4, "R6 mul small");
    drive(1, 4, 8'h10, 8'h10, 8'h00, "R6 mul over");
    drive(1, 4, 8'hFF, 8'hFF, 8'h80, "R6 mul max");
    drive(1, 4, 8'h0F, 8'h11, 8'h00, "R6 mul 255");
    drive(1, 5, 8'd200, 8'd7, 8'h84, "R7 div");
    drive(1, 5, 8'd5, 8'd9, 8'h00, "R7 div small");
    drive(1, 5, 8'h55, 8'h00, 8'h98, "R7 div zero");
    drive(1, 0, 8'h07, 8'h00, 8'hE6, "R8 R10 idle odd");
    drive(1, 6, 8'h03, 8'h01, 8'h5A, "R10 code6");
    drive(1, 7, 8'h01, 8'h01, 8'h3F, "R10 code7");
    drive(0, 1, 8'hFF, 8'h01, 8'h10, "R10 go low");
    drive(0, 4, 8'h81, 8'h02, 8'h08, "R8 go low mul");
    for (int i = 0; i < 120; i++) begin
      int a, b, p, op;
      a = (i * 73 + 29) & 255;
      b = (i * 151 + 7) & 255;
      p = (i * 57 + 3) & 255;
      op = i % 8;
      drive(1, op, a, b, p, "R2 R6 sweep");
    end
    drive(0, 0, 0, 0, 0, "R8 drain");
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule